// File: doc/BRIEF.md
# I2C Master Arbitration Loss Detector

This block watches an I2C controller while it acts as master transmitter and decides when that controller has lost bus arbitration to another master. It compares the SDA level the controller itself puts out with the synchronized SDA pin at each rising SCL edge, and it applies one of two additional rule sets chosen by a select input. The first extra rule catches the SCL line falling while the controller still holds its own SCL high. The second catches another device pulling SDA low after a start has been requested but before this controller has driven SDA low.

When any rule fires, a sticky loss flag is raised, a code giving the reason is stored, and a one-cycle release request tells the master engine to let go of SDA and SCL and to leave master mode. Software clears the flag by accessing the data register in the direction that matches the transfer mode, or by reading the flag as 1 and then writing 0 to it. Clock generation and byte shifting belong to neighbouring blocks.

Top module: `arb_loss_monitor`

## Requirements
- R1: After synchronous reset, `lost_flag` is 0, `lost_cause` is 0 and `release_req` is 0.
- R2: With `master_tx` high, a `scl_rise` strobe while `sda_drv` is 1 and `sda_pin` is 0 sets `lost_flag` after the edge, under either value of `rule_sel`; `sda_drv` low, or both levels high, causes no loss.
- R3: With `rule_sel` 0 and `master_tx` high, a `scl_fall` strobe while `scl_drv` is 1 sets `lost_flag`; with `rule_sel` 1 this condition is ignored.
- R4: With `rule_sel` 1, a start window opens in the cycle after `start_req` is seen with `master_tx` high and closes after a cycle in which `sda_drv` is 0 or `master_tx` is 0; while it is open, `sda_drv` 1 with `sda_pin` 0 sets `lost_flag`. With `rule_sel` 0 this condition is ignored.
- R5: No condition sets `lost_flag` while `master_tx` is 0.
- R6: `lost_flag` holds until cleared; `dreg_wr` with `xmit` 1 clears it and `dreg_rd` with `xmit` 0 clears it, while `dreg_wr` with `xmit` 0 and `dreg_rd` with `xmit` 1 do not.
- R7: `flag_wr0` clears the flag only if `flag_rd` was strobed while `lost_flag` was 1 at some cycle since the last clear request; a `flag_wr0` without such a read is ignored.
- R8: A detection and a clear request in the same cycle leave `lost_flag` at 1.
- R9: `release_req` is 1 for exactly the cycle after each cycle that contains a detection, and is otherwise 0.
- R10: `lost_cause` holds the code of the most recent detection, 1 = SDA mismatch, 2 = SCL held high, 3 = early SDA low; when several fire at once the priority is 1 over 2 over 3; a clear that takes effect returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_tx | input | 1 | Controller is master transmitter |
| xmit | input | 1 | Transfer direction: 1 transmit, 0 receive |
| rule_sel | input | 1 | Rule set select: 0 adds SCL-held check, 1 adds early-SDA-low check |
| sda_drv | input | 1 | Internal SDA output level (1 = released) |
| scl_drv | input | 1 | Internal SCL output level (1 = released) |
| sda_pin | input | 1 | Synchronized SDA pin level |
| scl_rise | input | 1 | Strobe: rising edge seen on SCL line |
| scl_fall | input | 1 | Strobe: falling edge seen on SCL line |
| start_req | input | 1 | Strobe: start condition requested |
| dreg_wr | input | 1 | Strobe: data register written |
| dreg_rd | input | 1 | Strobe: data register read |
| flag_rd | input | 1 | Strobe: software reads the loss flag |
| flag_wr0 | input | 1 | Strobe: software writes 0 to the loss flag |
| lost_flag | output | 1 | Sticky arbitration loss flag |
| lost_cause | output | 2 | Reason code of the latest detection |
| release_req | output | 1 | One-cycle request to release the bus and leave master mode |

## Verification
The hardest situation to reach is the early-SDA-low rule, because it only applies inside a start window that opens one cycle after the start request and is shut the moment the controller drives SDA low. The stimulus first drives the conflict in the very cycle of `start_req` (no loss expected), then holds it one cycle longer to catch it inside the window, and separately closes the window with a low `sda_drv` before presenting the conflict. The read-then-write-zero clear is reached by issuing a bare write first, then a read while the flag is set, then the write.

// File: rtl/arbl_pkg.sv
package arbl_pkg;

    localparam int CAUSE_W = 2;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_SDA   = 2'd1,
        CAUSE_SCL   = 2'd2,
        CAUSE_EARLY = 2'd3
    } loss_cause_t;

    typedef struct packed {
        logic sda_mis;
        logic scl_held;
        logic early;
    } det_t;

    function automatic logic any_det(input det_t d);
        return d.sda_mis | d.scl_held | d.early;
    endfunction

    function automatic loss_cause_t pick_cause(input det_t d);
        if (d.sda_mis)       return CAUSE_SDA;
        else if (d.scl_held) return CAUSE_SCL;
        else if (d.early)    return CAUSE_EARLY;
        else                 return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/arbl_window.sv
module arbl_window (
    input  logic clk,
    input  logic rst,
    input  logic master_tx,
    input  logic start_req,
    input  logic sda_drv,
    output logic armed
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst)            armed_q <= 1'b0;
        else if (!master_tx) armed_q <= 1'b0;
        else if (start_req) armed_q <= 1'b1;
        else if (!sda_drv)  armed_q <= 1'b0;
    end

    assign armed = armed_q;

    // R4: window shuts once the controller drives SDA low
    p_window_close_r4: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !sda_drv && !start_req) |=> !armed_q);

    // R4: window only opens from a start request
    p_window_open_r4: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !start_req) |=> !armed_q);
endmodule

// File: rtl/arbl_detect.sv
module arbl_detect
    import arbl_pkg::*;
(
    input  logic master_tx,
    input  logic rule_sel,
    input  logic armed,
    input  logic sda_drv,
    input  logic scl_drv,
    input  logic sda_pin,
    input  logic scl_rise,
    input  logic scl_fall,
    output det_t det
);
    logic sda_conflict;

    always_comb begin
        sda_conflict = sda_drv & ~sda_pin;
        det.sda_mis  = master_tx & scl_rise & sda_conflict;
        det.scl_held = master_tx & ~rule_sel & scl_fall & scl_drv;
        det.early    = master_tx & rule_sel & armed & sda_conflict;
    end
endmodule

// File: rtl/arbl_flag.sv
module arbl_flag
    import arbl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  det_t        det,
    input  logic        clr_data,
    input  logic        flag_rd,
    input  logic        flag_wr0,
    output logic        flag,
    output loss_cause_t cause,
    output logic        release_pulse
);
    logic        flag_q, seen_q, rel_q;
    loss_cause_t cause_q;
    logic        set_evt, clr_req;

    always_comb begin
        set_evt = any_det(det);
        clr_req = clr_data | (flag_wr0 & seen_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
            seen_q  <= 1'b0;
            rel_q   <= 1'b0;
        end else begin
            rel_q <= set_evt;
            if (set_evt) begin
                flag_q  <= 1'b1;
                cause_q <= pick_cause(det);
            end else if (clr_req) begin
                flag_q  <= 1'b0;
                cause_q <= CAUSE_NONE;
            end
            if (clr_req)                seen_q <= 1'b0;
            else if (flag_rd && flag_q) seen_q <= 1'b1;
        end
    end

    assign flag          = flag_q;
    assign cause         = cause_q;
    assign release_pulse = rel_q;

    // R8: hardware set beats any clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag_q);

    // R6: flag is sticky without a clear
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_req) |=> flag_q);

    // R7: bare write of zero is ignored
    p_wr0_needs_read_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !seen_q && !clr_data && flag_wr0) |=> flag_q);

    // R10: a raised flag always carries a reason
    p_cause_valid_r10: assert property (@(posedge clk) disable iff (rst)
        flag_q |-> (cause_q != CAUSE_NONE));
endmodule

// File: rtl/arb_loss_monitor.sv
module arb_loss_monitor
    import arbl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               master_tx,
    input  logic               xmit,
    input  logic               rule_sel,
    input  logic               sda_drv,
    input  logic               scl_drv,
    input  logic               sda_pin,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_req,
    input  logic               dreg_wr,
    input  logic               dreg_rd,
    input  logic               flag_rd,
    input  logic               flag_wr0,
    output logic               lost_flag,
    output logic [CAUSE_W-1:0] lost_cause,
    output logic               release_req
);
    logic        armed;
    det_t        det;
    logic        clr_data;
    loss_cause_t cause;

    assign clr_data = (dreg_wr & xmit) | (dreg_rd & ~xmit);

    arbl_window u_window (
        .clk       (clk),
        .rst       (rst),
        .master_tx (master_tx),
        .start_req (start_req),
        .sda_drv   (sda_drv),
        .armed     (armed)
    );

    arbl_detect u_detect (
        .master_tx (master_tx),
        .rule_sel  (rule_sel),
        .armed     (armed),
        .sda_drv   (sda_drv),
        .scl_drv   (scl_drv),
        .sda_pin   (sda_pin),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .det       (det)
    );

    arbl_flag u_flag (
        .clk           (clk),
        .rst           (rst),
        .det           (det),
        .clr_data      (clr_data),
        .flag_rd       (flag_rd),
        .flag_wr0      (flag_wr0),
        .flag          (lost_flag),
        .cause         (cause),
        .release_pulse (release_req)
    );

    assign lost_cause = cause;

    // R9: a release request comes with the raised flag
    p_release_flag_r9: assert property (@(posedge clk) disable iff (rst)
        release_req |-> lost_flag);

    // R5: nothing is detected outside master transmit
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !master_tx |=> !release_req);
endmodule

// File: tb/arb_loss_monitor_tb_top.sv
module arb_loss_monitor_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_tx = 0, xmit = 1, rule_sel = 0;
    logic sda_drv = 1, scl_drv = 1, sda_pin = 1;
    logic scl_rise = 0, scl_fall = 0, start_req = 0;
    logic dreg_wr = 0, dreg_rd = 0, flag_rd = 0, flag_wr0 = 0;
    logic       lost_flag, release_req;
    logic [1:0] lost_cause;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit m_flag = 0, m_seen = 0, m_armed = 0, m_rel = 0;
    int m_cause = 0;

    always #4 clk = ~clk;

    arb_loss_monitor dut_i (
        .clk(clk), .rst(rst), .master_tx(master_tx), .xmit(xmit),
        .rule_sel(rule_sel), .sda_drv(sda_drv), .scl_drv(scl_drv),
        .sda_pin(sda_pin), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_req(start_req), .dreg_wr(dreg_wr), .dreg_rd(dreg_rd),
        .flag_rd(flag_rd), .flag_wr0(flag_wr0), .lost_flag(lost_flag),
        .lost_cause(lost_cause), .release_req(release_req)
    );

    task automatic tick(input string tag);
        bit a, b, c, clr, hit;
        @(posedge clk);
        if (rst) begin
            m_flag = 0; m_seen = 0; m_armed = 0; m_rel = 0; m_cause = 0;
        end else begin
            a = master_tx && scl_rise && sda_drv && !sda_pin;
            b = master_tx && !rule_sel && scl_fall && scl_drv;
            c = master_tx && rule_sel && m_armed && sda_drv && !sda_pin;
            hit = a || b || c;
            clr = (dreg_wr && xmit) || (dreg_rd && !xmit) || (flag_wr0 && m_seen);
            m_rel = hit;
            if (hit) begin
                m_flag = 1;
                m_cause = a ? 1 : (b ? 2 : 3);
            end else if (clr) begin
                m_flag = 0;
                m_cause = 0;
            end
            if (clr) m_seen = 0;
            else if (flag_rd && lost_flag) m_seen = 1;
            if (!master_tx) m_armed = 0;
            else if (start_req) m_armed = 1;
            else if (!sda_drv) m_armed = 0;
        end
        @(negedge clk);
        checks++;
        if (lost_flag !== m_flag || int'(lost_cause) != m_cause || release_req !== m_rel) begin
            errors++;
            $display("FAIL %s: flag/cause/release actual %0b/%0d/%0b expected %0b/%0d/%0b",
                     tag, lost_flag, lost_cause, release_req, m_flag, m_cause, m_rel);
        end
        scl_rise = 0; scl_fall = 0; start_req = 0;
        dreg_wr = 0; dreg_rd = 0; flag_rd = 0; flag_wr0 = 0;
    endtask

    task automatic expect_flag(input string tag, input bit exp);
        checks++;
        if (lost_flag !== exp) begin
            errors++;
            $display("FAIL %s: lost_flag actual %0b expected %0b", tag, lost_flag, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick("R1"); tick("R1");
        rst = 0;
        tick("R1");
        expect_flag("R1", 0);

        // R2 mismatch under rule set 0, then clear by transmit write (R6)
        master_tx = 1; rule_sel = 0;
        sda_drv = 1; sda_pin = 0; scl_rise = 1; tick("R2");
        expect_flag("R2", 1);
        sda_pin = 1; tick("R9");
        dreg_wr = 1; xmit = 1; tick("R6");
        expect_flag("R6", 0);

        // R2 under rule set 1
        rule_sel = 1; sda_pin = 0; scl_rise = 1; tick("R2");
        expect_flag("R2", 1);
        xmit = 0; dreg_rd = 1; sda_pin = 1; tick("R6");
        expect_flag("R6", 0);

        // R2 no-loss patterns
        sda_drv = 0; sda_pin = 0; scl_rise = 1; tick("R2");
        sda_drv = 1; sda_pin = 1; scl_rise = 1; tick("R2");
        expect_flag("R2", 0);

        // R3 rule set 0, clear by read-then-write-zero (R7)
        rule_sel = 0; scl_drv = 1; scl_fall = 1; tick("R3");
        expect_flag("R3", 1);
        flag_wr0 = 1; tick("R7");
        expect_flag("R7", 1);
        flag_rd = 1; tick("R7");
        flag_wr0 = 1; tick("R7");
        expect_flag("R7", 0);

        // R3 ignored under rule set 1
        rule_sel = 1; scl_fall = 1; tick("R3");
        expect_flag("R3", 0);

        // R4 early low: same cycle as start request does not count
        sda_drv = 1; sda_pin = 0; start_req = 1; tick("R4");
        expect_flag("R4", 0);
        tick("R4");
        expect_flag("R4", 1);
        sda_pin = 1; xmit = 0; dreg_rd = 1; tick("R4");
        // window closed by own SDA low
        start_req = 1; tick("R4");
        sda_drv = 0; tick("R4");
        sda_drv = 1; sda_pin = 0; tick("R4");
        expect_flag("R4", 0);
        // R4 ignored under rule set 0
        sda_pin = 1; rule_sel = 0; start_req = 1; tick("R4");
        sda_pin = 0; tick("R4");
        expect_flag("R4", 0);
        sda_pin = 1;

        // R5 no detection outside master transmit
        master_tx = 0; sda_pin = 0; scl_rise = 1; scl_fall = 1; tick("R5");
        expect_flag("R5", 0);
        sda_pin = 1; master_tx = 1;

        // R10 priority and overwrite
        sda_pin = 0; scl_rise = 1; scl_fall = 1; tick("R10");
        sda_pin = 1; scl_fall = 1; tick("R10");
        // R6 wrong-direction accesses keep flag
        xmit = 0; dreg_wr = 1; tick("R6");
        xmit = 1; dreg_rd = 1; tick("R6");
        expect_flag("R6", 1);

        // R8 set and clear together
        scl_fall = 1; dreg_wr = 1; tick("R8");
        expect_flag("R8", 1);
        dreg_wr = 1; tick("R8");
        expect_flag("R8", 0);
        tick("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule